// File: doc/BRIEF.md
# ADC Overload Flag and Startup Mute

This block sits behind the decimation stage of a stereo recording path. It watches the signed left and right samples, which arrive with a one-cycle sample strobe. It raises an overload flag whenever either channel comes within about 1.16 dB of digital full scale. The flag then stays up for a fixed number of sample periods after the last offending sample, so that a record-level control has time to see it.

The block also decides when the serial ADC output may carry real data. After reset, or after a restart pulse (power-down recovery, clock start), the output is held muted for a number of sample periods. That number depends on whether the DC-cancel high-pass filter is enabled, because the filter needs far longer to settle. While the output is muted, the overload flag is forced low.

The serializer downstream uses `out_live` to choose between the sample and zero. The flag drives a level indicator or gain control.

Top module: `rec_level_guard`

## Requirements
- R1: After reset, `ovl_flag` is 0 and `out_live` is 0. The mute window starts counting from zero strobes.
- R2: A sample overloads when its magnitude is strictly greater than T = round((2^(W-1)-1) × 0.874983), where W is the sample width. T is 458742 for W = 20. A magnitude equal to T does not overload. The test applies to the left and right channels alike, and to positive and negative values alike.
- R3: The most negative code, -2^(W-1), always counts as an overload.
- R4: When the output is live and a strobed sample overloads on either channel, `ovl_flag` is 1 from the next clock edge.
- R5: After the last overloading sample, `ovl_flag` stays 1 through 511 further non-overloading strobes. It reads 0 after the 512th. Cycles without a strobe do not shorten the hold.
- R6: Every overloading sample reloads the full 512-strobe hold, so sustained or repeated overload keeps the flag high.
- R7: With `dc_cancel_en` = 0, `out_live` goes to 1 at the edge of the 1024th strobe since the mute window started. Once live, the output stays live until the next restart.
- R8: With `dc_cancel_en` = 1, the mute window lasts 12288 strobes instead of 1024.
- R9: A `restart` pulse makes `out_live` 0 from the next edge and restarts the window count from zero. This applies both when the output is live and while it is already muted.
- R10: A change of `dc_cancel_en` while muted restarts the window count from zero, and the new setting picks the length. A change while live has no effect on `out_live`.
- R11: While `out_live` is 0, `ovl_flag` is 0. Overloading samples during the mute window do not set the flag. A restart clears a flag that was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| smp_left | input | W | Left sample, two's complement |
| smp_right | input | W | Right sample, two's complement |
| dc_cancel_en | input | 1 | 1 when the DC-cancel filter is in use (selects the long mute window) |
| restart | input | 1 | One-cycle pulse that starts a new mute window |
| ovl_flag | output | 1 | Overload indication, held after the last overload |
| out_live | output | 1 | 1 when the serial output may carry samples, 0 when it must be muted |

## Verification
Both outputs come straight from registers, so each response is due at the first clock edge after the stimulus that causes it. This holds for a strobed sample, a restart pulse or a change of the DC-cancel setting. The bench changes its inputs 1 ns after a rising edge, lets exactly one edge pass, and reads the outputs 1 ns after it. Each check therefore sees the state produced by that edge alone.

Window boundaries are checked at count N-1 and at count N. Non-strobe gaps are placed inside both the hold window and the mute window, which proves that only strobes advance those counts.

// File: rtl/guard_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the overload and startup-mute block.
// Assumes sample widths up to 32 bits, so the threshold fits a longint.
package guard_pkg;

    // Output gating state of the startup blanking counter.
    typedef enum logic {
        ST_MUTE = 1'b0,
        ST_LIVE = 1'b1
    } gate_state_t;

    // Overload threshold: full scale times 10^(-1.16/20), rounded to nearest.
    function automatic longint over_thresh(input int width);
        longint full_scale;
        full_scale = (longint'(1) << (width - 1)) - 1;
        return (full_scale * 874983 + 500000) / 1000000;
    endfunction

endpackage

// File: rtl/ovl_detect.sv
`timescale 1ns/1ps
// Combinational near-full-scale detector for a set of channels.
// Each channel's magnitude is compared against the fixed threshold.
// Assumes two's complement samples; the negated minimum code fits in W+1 bits.
module ovl_detect #(
    parameter int W     = 20,
    parameter int CHANS = 2
) (
    input  logic [CHANS-1:0][W-1:0] smp_i,
    output logic                    over_o
);
    localparam logic [W:0] THRESH = (W+1)'(guard_pkg::over_thresh(W));

    logic [CHANS-1:0] hit;

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
        logic signed [W:0] ext;
        logic signed [W:0] mag;

        // Widen by one bit and take the absolute value of this channel.
        always_comb begin
            ext = {smp_i[ch][W-1], smp_i[ch]};
            mag = ext[W] ? -ext : ext;
        end

        // Flag this channel when its magnitude is strictly above threshold.
        assign hit[ch] = $unsigned(mag) > THRESH;
    end

    assign over_o = |hit;

endmodule

// File: rtl/ovl_hold.sv
`timescale 1ns/1ps
// Retriggerable overload hold timer, counted in sample strobes.
// An overload strobe loads HOLD; each clean strobe counts down; flag = nonzero.
// Assumes clear_i covers both muted periods and restart pulses.
module ovl_hold #(
    parameter int HOLD = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic strobe_i,
    input  logic over_i,
    output logic flag_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] left_q;

    // Load on overload, decay on clean strobes, clear on reset or mute.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            left_q <= '0;
        end else if (strobe_i) begin
            if (over_i) begin
                left_q <= CW'(HOLD);
            end else if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign flag_o = (left_q != '0);

    // R4: a live overload strobe raises the flag at the next edge.
    a_r4_flag_on_overload: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i && over_i && !clear_i |=> flag_o);

    // R5: the remaining-hold count never exceeds the hold length.
    a_r5_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CW'(HOLD));

    // R5: cycles without a strobe do not shorten the hold.
    a_r5_idle_no_decay: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i && !clear_i |=> $stable(left_q));

endmodule

// File: rtl/startup_blank.sv
`timescale 1ns/1ps
// Startup mute window: counts strobes after reset or restart.
// Goes live after SHORT strobes (DC cancel off) or LONG strobes (on).
// Assumes LONG >= SHORT >= 1. A DC-cancel change while muted restarts the count.
module startup_blank #(
    parameter int SHORT = 1024,
    parameter int LONG  = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic dc_en_i,
    input  logic strobe_i,
    output logic live_o
);
    import guard_pkg::*;

    localparam int CW = $clog2(LONG + 1);

    gate_state_t   state_q;
    logic [CW-1:0] cnt_q;
    logic          dc_q;
    logic [CW-1:0] limit;

    // Index of the last strobe of the window for the current setting.
    assign limit = dc_en_i ? CW'(LONG - 1) : CW'(SHORT - 1);

    // Track the setting, count strobes while muted, and go live at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MUTE;
            cnt_q   <= '0;
            dc_q    <= dc_en_i;
        end else begin
            dc_q <= dc_en_i;
            if (restart_i) begin
                state_q <= ST_MUTE;
                cnt_q   <= '0;
            end else if (state_q == ST_MUTE) begin
                if (dc_en_i != dc_q) begin
                    cnt_q <= '0;
                end else if (strobe_i) begin
                    if (cnt_q == limit) begin
                        state_q <= ST_LIVE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign live_o = (state_q == ST_LIVE);

    // R9: a restart mutes the output at the next edge.
    a_r9_restart_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !live_o);

    // R7: once live, the output stays live until a restart.
    a_r7_live_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        live_o && !restart_i |=> live_o);

    // R7: going live is always caused by a strobe.
    a_r7_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live_o) |-> $past(strobe_i));

    // R10: a setting change while muted zeroes the count.
    a_r10_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !live_o && !restart_i && (dc_en_i != dc_q) |=> (cnt_q == '0) && !live_o);

endmodule

// File: rtl/rec_level_guard.sv
`timescale 1ns/1ps
// Top level: overload flag with hold, plus startup output muting.
// The flag is cleared and suppressed while the output is muted or restarting.
// Assumes one strobe per stereo sample period, left and right valid together.
module rec_level_guard #(
    parameter int W            = 20,
    parameter int HOLD_SAMPLES = 512,
    parameter int BLANK_SHORT  = 1024,
    parameter int BLANK_LONG   = 12288
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_left,
    input  logic [W-1:0] smp_right,
    input  logic         dc_cancel_en,
    input  logic         restart,
    output logic         ovl_flag,
    output logic         out_live
);
    logic [1:0][W-1:0] pair;
    logic              over;
    logic              hold_clear;

    // Pack both channels for the detector.
    assign pair = {smp_right, smp_left};

    ovl_detect #(.W(W), .CHANS(2)) u_detect (
        .smp_i  (pair),
        .over_o (over)
    );

    startup_blank #(.SHORT(BLANK_SHORT), .LONG(BLANK_LONG)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .dc_en_i   (dc_cancel_en),
        .strobe_i  (smp_valid),
        .live_o    (out_live)
    );

    // Clear the hold while muted or when a new window is starting.
    assign hold_clear = !out_live || restart;

    ovl_hold #(.HOLD(HOLD_SAMPLES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (hold_clear),
        .strobe_i (smp_valid),
        .over_i   (over),
        .flag_o   (ovl_flag)
    );

    // R11: no overload indication while the output is muted.
    a_r11_flag_low_muted: assert property (@(posedge clk) disable iff (!rst_n)
        !out_live |-> !ovl_flag);

    // R3: the most negative left code raises the flag when live.
    a_r3_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && out_live && !restart && (smp_left == {1'b1, {(W-1){1'b0}}})
        |=> ovl_flag);

endmodule

// File: tb/tb_rec_level_guard.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_rec_level_guard;
    localparam int W    = 20;
    localparam int HOLD = 512;
    localparam int BS   = 1024;
    localparam int BL   = 12288;
    localparam int T    = 458742;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic signed [W-1:0] smp_left = '0;
    logic signed [W-1:0] smp_right = '0;
    logic                dc_cancel_en = 1'b0;
    logic                restart = 1'b0;
    logic                ovl_flag;
    logic                out_live;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rec_level_guard #(.W(W), .HOLD_SAMPLES(HOLD), .BLANK_SHORT(BS), .BLANK_LONG(BL)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
        .smp_right(smp_right), .dc_cancel_en(dc_cancel_en), .restart(restart),
        .ovl_flag(ovl_flag), .out_live(out_live)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input int l, input int r);
        smp_valid = 1'b1;
        smp_left  = W'(l);
        smp_right = W'(r);
        tick();
        smp_valid = 1'b0;
        smp_left  = '0;
        smp_right = '0;
    endtask

    task automatic clean(input int n);
        for (int i = 0; i < n; i++) strobe(1000, -1000);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        tick();
        restart = 1'b0;
    endtask

    // R5: flag holds through 511 clean strobes (with a gap), drops on the 512th.
    task automatic drain(input string req);
        clean(256);
        idle(20);
        check(req, "flag mid-hold after idle gap", ovl_flag, 1'b1);
        clean(HOLD - 257);
        check(req, "flag after 511 clean strobes", ovl_flag, 1'b1);
        clean(1);
        check(req, "flag after 512 clean strobes", ovl_flag, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        tick();
        check("R1", "flag after reset", ovl_flag, 1'b0);
        check("R1", "live after reset", out_live, 1'b0);
    endtask

    task automatic t_short_window();
        clean(500);
        idle(50);
        check("R7", "live after 500 strobes and gap", out_live, 1'b0);
        clean(523);
        check("R7", "live after 1023 strobes", out_live, 1'b0);
        clean(1);
        check("R7", "live after 1024 strobes", out_live, 1'b1);
        idle(10);
        check("R7", "live stays without restart", out_live, 1'b1);
    endtask

    task automatic t_threshold();
        strobe(T, 0);
        check("R2", "flag at +T left", ovl_flag, 1'b0);
        strobe(0, -T);
        check("R2", "flag at -T right", ovl_flag, 1'b0);
        strobe(T + 1, 0);
        check("R4", "flag at +T+1 left", ovl_flag, 1'b1);
        drain("R5");
        strobe(0, -(T + 1));
        check("R2", "flag at -(T+1) right", ovl_flag, 1'b1);
        drain("R5");
    endtask

    task automatic t_min_code();
        strobe(-(1 << (W - 1)), 0);
        check("R3", "flag on most negative left", ovl_flag, 1'b1);
        drain("R3");
        strobe(0, -(1 << (W - 1)));
        check("R3", "flag on most negative right", ovl_flag, 1'b1);
        drain("R3");
    endtask

    task automatic t_retrigger();
        strobe(T + 1, 0);
        clean(300);
        check("R6", "flag 300 strobes in", ovl_flag, 1'b1);
        strobe(0, T + 5);
        clean(HOLD - 1);
        check("R6", "flag 511 strobes after retrigger", ovl_flag, 1'b1);
        clean(1);
        check("R6", "flag 512 strobes after retrigger", ovl_flag, 1'b0);
    endtask

    task automatic t_dc_change_live();
        dc_cancel_en = 1'b1;
        tick();
        check("R10", "live after setting change while live", out_live, 1'b1);
        dc_cancel_en = 1'b0;
        idle(2);
        check("R10", "live after setting restored", out_live, 1'b1);
    endtask

    task automatic t_restart();
        strobe(T + 1, 0);
        check("R4", "flag before restart", ovl_flag, 1'b1);
        pulse_restart();
        check("R9", "live after restart", out_live, 1'b0);
        check("R11", "flag cleared by restart", ovl_flag, 1'b0);
        strobe(T + 1, T + 1);
        check("R11", "overload ignored while muted", ovl_flag, 1'b0);
        clean(499);
        pulse_restart();
        check("R9", "live after restart mid-window", out_live, 1'b0);
        clean(600);
        strobe(-(1 << (W - 1)), 0);
        check("R11", "min code ignored while muted", ovl_flag, 1'b0);
        clean(422);
        check("R9", "live at 1023 after second restart", out_live, 1'b0);
        clean(1);
        check("R9", "live at 1024 after second restart", out_live, 1'b1);
        check("R11", "flag stays low after going live", ovl_flag, 1'b0);
    endtask

    task automatic t_dc_change_muted();
        dc_cancel_en = 1'b1;
        pulse_restart();
        clean(100);
        dc_cancel_en = 1'b0;
        tick();
        clean(1023);
        check("R10", "live 1023 strobes after change", out_live, 1'b0);
        clean(1);
        check("R10", "live 1024 strobes after change", out_live, 1'b1);
    endtask

    task automatic t_long_window();
        dc_cancel_en = 1'b1;
        pulse_restart();
        clean(BS);
        check("R8", "live at 1024 with DC cancel", out_live, 1'b0);
        clean(BL - BS - 1);
        check("R8", "live at 12287 with DC cancel", out_live, 1'b0);
        clean(1);
        check("R8", "live at 12288 with DC cancel", out_live, 1'b1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        t_reset();
        t_short_window();
        t_threshold();
        t_min_code();
        t_retrigger();
        t_dc_change_live();
        t_restart();
        t_dc_change_muted();
        t_long_window();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule